// File: doc/BRIEF.md
# Priority Bus Request Arbiter

This block decides which device becomes the next master of a shared bus that carries one master at a time. Devices request the bus on one of two classes of line. The first is a single direct-memory request line that may be served at any point, including in the middle of an instruction. The second is a set of four interrupt-capable request levels, numbered 4 to 7. Each class has its own grant output, and that grant is daisy-chained outside the block. The grant stops at the first requesting device on the chain, so the device wired nearest the arbiter wins on its line.

The direct-memory line always beats every level. A level request is served only while the processor signals an instruction boundary, and only when the level is strictly above the processor's current 3-bit priority. Among the eligible levels, the highest one wins. Once a device acknowledges its grant, every grant is withdrawn, and no new grant is issued until that device has taken the bus. The device shows this by dropping its acknowledge while bus busy is asserted. Arbitration then resumes while the new master is still transferring, so the choice of the following master overlaps the current transfer.

Top module: `bus_grant_arbiter`

## Requirements
- R1: While `rst_n` is low at a clock edge, all grant outputs are low after that edge and any pending selection is discarded.
- R2: With the arbiter idle and `sel_ack` low, a high `npr_req` raises `npr_grant` after the next clock edge, whatever the value of `instr_end`.
- R3: When `npr_req` and an eligible level request are present at the same edge, only `npr_grant` is raised.
- R4: A level grant `br_grant[i]` (bit i serves level 4+i) is raised only at an edge where `instr_end` is high. Without `instr_end`, a pending level request gets no grant.
- R5: Level 4+i is eligible only when 4+i is strictly greater than `cpu_pri`. A level equal to or below `cpu_pri` is never granted.
- R6: When several eligible levels request at once, only the highest level is granted.
- R7: At most one of the five grant outputs is high in any cycle.
- R8: The edge after `sel_ack` is seen high with a grant up, all grants are low. No grant is issued while `sel_ack` stays high. No grant is issued after `sel_ack` falls until `bus_busy` has been seen high with `sel_ack` low.
- R9: If the granted request line drops before `sel_ack` arrives, its grant falls at the next edge.
- R10: The edge that sees `sel_ack` low with `bus_busy` high closes the selection. A pending request can then be granted at the following edge while `bus_busy` is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| npr_req | input | 1 | Direct-memory (non-processor) request, active high |
| br_req | input | 4 | Level requests, bit i is level 4+i, active high |
| cpu_pri | input | 3 | Current processor priority |
| instr_end | input | 1 | Instruction boundary strobe |
| sel_ack | input | 1 | Selection acknowledge from the granted device |
| bus_busy | input | 1 | Bus busy, driven by the current master |
| npr_grant | output | 1 | Grant for the direct-memory chain |
| br_grant | output | 4 | Grants for the level chains, bit i is level 4+i |

## Verification
The assertions assume that a device raises `sel_ack` only in response to a grant it saw. They also assume that the device holds `sel_ack` until it has taken the bus, and that it raises `bus_busy` when it drops `sel_ack`. The stimulus follows this protocol in every scenario. It raises `sel_ack` only after a grant has been observed, and it lowers `sel_ack` either together with raising `bus_busy` or with `bus_busy` deliberately held low to probe the closing rule. Inputs change only just after a falling clock edge, so every property sees stable values at the rising edge.

// File: rtl/arb_pkg.sv
// Shared types for the bus request arbiter.
package arb_pkg;
    // Arbiter phase: free to grant, grant offered, selection held
    typedef enum logic [1:0] {
        ARB_IDLE  = 2'd0,
        ARB_OFFER = 2'd1,
        ARB_HELD  = 2'd2
    } arb_state_e;
endpackage

// File: rtl/arb_level_pick.sv
// Picks the highest request level strictly above the processor priority.
// Assumes bit i of br_req stands for level BASE_LVL+i, higher index = higher level.
module arb_level_pick #(
    parameter int NUM_BR   = 4,
    parameter int BASE_LVL = 4,
    parameter int PRI_W    = 3,
    parameter int IDX_W    = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
    input  logic [NUM_BR-1:0] br_req,
    input  logic [PRI_W-1:0]  cpu_pri,
    output logic              win_valid,
    output logic [IDX_W-1:0]  win_idx
);
    logic [NUM_BR-1:0] elig;

    // One comparator per level: request present and level above processor
    for (genvar i = 0; i < NUM_BR; i++) begin : g_elig
        localparam logic [PRI_W:0] LVL = (PRI_W+1)'(BASE_LVL + i);
        assign elig[i] = br_req[i] && (LVL > {1'b0, cpu_pri});
    end

    // Priority encode: the last eligible index scanned is the highest level
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = 0; i < NUM_BR; i++) begin
            if (elig[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/arb_grant_fsm.sv
// Grant sequencer: issues at most one grant, withdraws it on acknowledge
// or on request loss, and holds off further grants until the selected
// device has taken the bus (ack low while busy high).
// Grant vector bit NUM_BR is the direct-memory line, bits below are levels.
module arb_grant_fsm
    import arb_pkg::*;
#(
    parameter int NUM_BR = 4,
    parameter int IDX_W  = (NUM_BR > 1) ? $clog2(NUM_BR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              npr_req,
    input  logic [NUM_BR-1:0] br_req,
    input  logic              instr_end,
    input  logic              sel_ack,
    input  logic              bus_busy,
    input  logic              win_valid,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [NUM_BR:0]   grant_vec
);
    localparam int GV_W = NUM_BR + 1;

    arb_state_e      state_q, state_d;
    logic [NUM_BR:0] grant_q, grant_d;
    logic [NUM_BR:0] req_all;
    logic            held_req;

    assign req_all  = {npr_req, br_req};
    assign held_req = |(grant_q & req_all);

    // Next-state and next-grant decision
    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (!sel_ack) begin
                    if (npr_req) begin
                        grant_d = GV_W'(1) << NUM_BR;
                        state_d = ARB_OFFER;
                    end else if (instr_end && win_valid) begin
                        grant_d = GV_W'(1) << win_idx;
                        state_d = ARB_OFFER;
                    end
                end
            end
            ARB_OFFER: begin
                if (sel_ack) begin
                    grant_d = '0;
                    state_d = ARB_HELD;
                end else if (!held_req) begin
                    grant_d = '0;
                    state_d = ARB_IDLE;
                end
            end
            ARB_HELD: begin
                grant_d = '0;
                if (!sel_ack && bus_busy) state_d = ARB_IDLE;
            end
            default: begin
                grant_d = '0;
                state_d = ARB_IDLE;
            end
        endcase
    end

    // State and grant registers with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            grant_q <= grant_d;
        end
    end

    assign grant_vec = grant_q;
endmodule

// File: rtl/bus_grant_arbiter.sv
// Top of the bus request arbiter: level selection feeding the grant
// sequencer. Assumes all inputs are synchronous to clk.
module bus_grant_arbiter #(
    parameter int NUM_BR   = 4,
    parameter int BASE_LVL = 4,
    parameter int PRI_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              npr_req,
    input  logic [NUM_BR-1:0] br_req,
    input  logic [PRI_W-1:0]  cpu_pri,
    input  logic              instr_end,
    input  logic              sel_ack,
    input  logic              bus_busy,
    output logic              npr_grant,
    output logic [NUM_BR-1:0] br_grant
);
    localparam int IDX_W = (NUM_BR > 1) ? $clog2(NUM_BR) : 1;

    logic             win_valid;
    logic [IDX_W-1:0] win_idx;
    logic [NUM_BR:0]  grant_vec;

    arb_level_pick #(
        .NUM_BR(NUM_BR), .BASE_LVL(BASE_LVL), .PRI_W(PRI_W), .IDX_W(IDX_W)
    ) u_pick (
        .br_req   (br_req),
        .cpu_pri  (cpu_pri),
        .win_valid(win_valid),
        .win_idx  (win_idx)
    );

    arb_grant_fsm #(
        .NUM_BR(NUM_BR), .IDX_W(IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .npr_req  (npr_req),
        .br_req   (br_req),
        .instr_end(instr_end),
        .sel_ack  (sel_ack),
        .bus_busy (bus_busy),
        .win_valid(win_valid),
        .win_idx  (win_idx),
        .grant_vec(grant_vec)
    );

    assign npr_grant = grant_vec[NUM_BR];
    assign br_grant  = grant_vec[NUM_BR-1:0];
endmodule

// File: rtl/arb_checker.sv
// Protocol properties of the arbiter, observed at its ports only.
module arb_checker #(
    parameter int NUM_BR   = 4,
    parameter int BASE_LVL = 4,
    parameter int PRI_W    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              npr_req,
    input logic [NUM_BR-1:0] br_req,
    input logic [PRI_W-1:0]  cpu_pri,
    input logic              instr_end,
    input logic              sel_ack,
    input logic              bus_busy,
    input logic              npr_grant,
    input logic [NUM_BR-1:0] br_grant
);
    logic br_any;
    assign br_any = |br_grant;

    // R1: reset leaves every grant low
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!npr_grant && !br_any));

    // R7: never two grants at once
    assert_one_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({npr_grant, br_grant}));

    // R4: a fresh level grant needs an instruction boundary
    assert_br_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (br_any && !$past(br_any)) |-> $past(instr_end));

    // R3: a fresh level grant never happens with a direct-memory request pending
    assert_npr_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (br_any && !$past(br_any)) |-> !$past(npr_req));

    // R8: acknowledge withdraws every grant next cycle
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ack |=> (!npr_grant && !br_any));

    // R9: losing the request drops the direct-memory grant
    assert_npr_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (npr_grant && !npr_req && !sel_ack) |=> !npr_grant);

    // R5: a level grant only ever goes to a level above the processor
    for (genvar i = 0; i < NUM_BR; i++) begin : g_lvl
        localparam logic [PRI_W:0] LVL = (PRI_W+1)'(BASE_LVL + i);
        assert_level_above_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (br_grant[i] && !$past(br_grant[i])) |-> ({1'b0, $past(cpu_pri)} < LVL));
        // R9: losing a level request drops that grant
        assert_br_withdraw_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (br_grant[i] && !br_req[i] && !sel_ack) |=> !br_grant[i]);
    end
endmodule

bind bus_grant_arbiter arb_checker #(
    .NUM_BR(NUM_BR), .BASE_LVL(BASE_LVL), .PRI_W(PRI_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .npr_req  (npr_req),
    .br_req   (br_req),
    .cpu_pri  (cpu_pri),
    .instr_end(instr_end),
    .sel_ack  (sel_ack),
    .bus_busy (bus_busy),
    .npr_grant(npr_grant),
    .br_grant (br_grant)
);

// File: tb/bus_grant_arbiter_tb.sv
// Directed bench for the bus request arbiter.
module bus_grant_arbiter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       npr_req;
    logic [3:0] br_req;
    logic [2:0] cpu_pri;
    logic       instr_end;
    logic       sel_ack;
    logic       bus_busy;
    logic       npr_grant;
    logic [3:0] br_grant;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_grant_arbiter u_dut (
        .clk(clk), .rst_n(rst_n), .npr_req(npr_req), .br_req(br_req),
        .cpu_pri(cpu_pri), .instr_end(instr_end), .sel_ack(sel_ack),
        .bus_busy(bus_busy), .npr_grant(npr_grant), .br_grant(br_grant)
    );

    // Advance one rising edge, return just after the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Compare all grants with expectation, also check at most one high (R7)
    task automatic expect_grants(input logic exp_npr, input logic [3:0] exp_br,
                                 input string tag);
        checks++;
        if (npr_grant !== exp_npr || br_grant !== exp_br) begin
            failures++;
            $display("FAIL %s: grants npr=%b br=%b expected npr=%b br=%b",
                     tag, npr_grant, br_grant, exp_npr, exp_br);
        end
        checks++;
        if ($countones({npr_grant, br_grant}) > 1) begin
            failures++;
            $display("FAIL R7: %0d grants high, expected at most 1",
                     $countones({npr_grant, br_grant}));
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; npr_req = 1'b0; br_req = '0; cpu_pri = '0;
        instr_end = 1'b0; sel_ack = 1'b0; bus_busy = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
    endtask

    // R1: reset clears a live grant
    task automatic t_reset();
        do_reset();
        expect_grants(1'b0, 4'b0000, "R1 after reset");
        npr_req = 1'b1;
        tick();
        rst_n = 1'b0;
        tick();
        expect_grants(1'b0, 4'b0000, "R1 reset drops grant");
        rst_n = 1'b1; npr_req = 1'b0;
        tick();
    endtask

    // R2, R8, R10: mid-instruction grant, ack hold-off, overlapped re-arbitration
    task automatic t_npr_cycle();
        do_reset();
        npr_req = 1'b1;
        tick();
        expect_grants(1'b1, 4'b0000, "R2 npr without boundary");
        sel_ack = 1'b1; npr_req = 1'b0;
        br_req = 4'b1000; instr_end = 1'b1;
        tick();
        expect_grants(1'b0, 4'b0000, "R8 ack withdraws");
        tick();
        expect_grants(1'b0, 4'b0000, "R8 no grant while ack high");
        sel_ack = 1'b0;
        tick();
        expect_grants(1'b0, 4'b0000, "R8 ack low without busy keeps hold");
        bus_busy = 1'b1;
        tick();
        expect_grants(1'b0, 4'b0000, "R10 closing edge");
        tick();
        expect_grants(1'b0, 4'b1000, "R10 regrant during busy");
    endtask

    // R3: direct-memory beats level 7
    task automatic t_npr_wins();
        do_reset();
        npr_req = 1'b1; br_req = 4'b1000; instr_end = 1'b1;
        tick();
        expect_grants(1'b1, 4'b0000, "R3 npr over level");
    endtask

    // R4: level requests need an instruction boundary
    task automatic t_boundary();
        do_reset();
        br_req = 4'b0010;
        tick(); tick();
        expect_grants(1'b0, 4'b0000, "R4 no boundary no grant");
        instr_end = 1'b1;
        tick();
        expect_grants(1'b0, 4'b0010, "R4 granted at boundary");
    endtask

    // R5: strictly above processor priority
    task automatic t_priority();
        do_reset();
        cpu_pri = 3'd5; br_req = 4'b0010; instr_end = 1'b1;
        tick();
        expect_grants(1'b0, 4'b0000, "R5 equal level blocked");
        cpu_pri = 3'd7; br_req = 4'b1111;
        tick();
        expect_grants(1'b0, 4'b0000, "R5 pri 7 blocks all");
        cpu_pri = 3'd4; br_req = 4'b0011;
        tick();
        expect_grants(1'b0, 4'b0010, "R5 level 5 above pri 4");
    endtask

    // R6: highest eligible level wins
    task automatic t_highest();
        do_reset();
        br_req = 4'b0111; instr_end = 1'b1;
        tick();
        expect_grants(1'b0, 4'b0100, "R6 level 6 of 4..6");
        do_reset();
        cpu_pri = 3'd6; br_req = 4'b1001; instr_end = 1'b1;
        tick();
        expect_grants(1'b0, 4'b1000, "R6 level 7 only eligible");
    endtask

    // R9: grant withdrawn when request disappears before ack
    task automatic t_withdraw();
        do_reset();
        npr_req = 1'b1;
        tick();
        expect_grants(1'b1, 4'b0000, "R9 setup npr");
        npr_req = 1'b0;
        tick();
        expect_grants(1'b0, 4'b0000, "R9 npr withdrawn");
        br_req = 4'b0001; instr_end = 1'b1;
        tick();
        expect_grants(1'b0, 4'b0001, "R9 setup level 4");
        br_req = 4'b0000;
        tick();
        expect_grants(1'b0, 4'b0000, "R9 level withdrawn");
    endtask

    initial begin
        t_reset();
        t_npr_cycle();
        t_npr_wins();
        t_boundary();
        t_priority();
        t_highest();
        t_withdraw();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule